// File: doc/BRIEF.md
# Dual-Mode Multiply-Accumulate Unit

This block is a two-stage pipelined multiply-accumulate engine that takes two 32-bit operand words. It has three operating modes. In dual mode, the low halves and the high halves of the operands are multiplied separately, and each product goes into its own 40-bit accumulator. In wide mode, the full 32x32 product goes into one 72-bit accumulator, built by chaining the two 40-bit accumulators. In complex mode, each operand is read as a packed complex number, with the real part in the high half and the imaginary part in the low half. The real part of the product goes into the first accumulator and the imaginary part into the second.

Each operation carries its own control bits:
- signed or unsigned operands;
- start a new sum instead of adding to the old one;
- clamp the accumulator on overflow;
- round the extracted result.

One operation can be accepted every cycle. A valid flag travels with the data, so each result lines up with the operation that produced it. Outputs are the raw accumulators, two rounded and saturated 16-bit results, one rounded and saturated 32-bit result from the wide accumulator, and a sticky overflow flag for each accumulator.

Top module: `dmac_unit`

## Requirements
- R1: With `mode`=0 (or 3), `acc0` adds the product of the operands' bits 15:0 and `acc1` adds the product of bits 31:16. The halves are sign-extended when `is_signed`=1 and zero-extended otherwise.
- R2: With `mode`=1, the 72-bit value {`acc1`[31:0], `acc0`} adds the full 32x32 product, signed or unsigned per `is_signed`. Bits 39:32 of `acc1` copy bit 71 of the result, and `acc_wide` shows the 72-bit value.
- R3: With `mode`=2, the operands are read as signed (re = bits 31:16, im = bits 15:0). `acc0` adds re(a)·re(b) − im(a)·im(b), and `acc1` adds re(a)·im(b) + im(a)·re(b). `is_signed` is ignored in this mode.
- R4: With `clr_acc`=1, the accumulators affected by the operation load the new product instead of adding it to their old value.
- R5: With `sat_en`=1, an accumulation that leaves the signed range is clamped to the nearest limit. The range is 40 bits per accumulator in modes 0, 2 and 3, and 72 bits in mode 1. With `sat_en`=0, the sum wraps modulo 2^40 or 2^72.
- R6: `ovf0` is set when `acc0` is clamped. `ovf1` is set when `acc1` is clamped, or when the 72-bit accumulator is clamped. Both flags stay set until reset; a wrap does not set them.
- R7: `out_valid` and the updated accumulators appear two clock edges after `in_valid` is sampled high. Accumulators do not change while no operation is in flight, and back-to-back operations are accepted every cycle.
- R8: `res_lo` and `res_hi` are bits 31:16 of `acc0` and `acc1`, after adding 0x8000 when the latest operation had `rnd_en`=1. When that operation had `sat_en`=1 and the rounded value is outside the signed 32-bit range, the result is 0x7FFF for a positive value or 0x8000 for a negative one.
- R9: `res_wide` is bits 63:32 of the 72-bit accumulator, after adding 2^31 when `rnd_en`=1. When `sat_en`=1 and the rounded value is outside the signed 64-bit range, it is 0x7FFFFFFF or 0x80000000.
- R10: After reset, all accumulators, results, flags and `out_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op_a | input | 32 | First operand word |
| op_b | input | 32 | Second operand word |
| mode | input | 2 | 0/3 dual, 1 wide, 2 complex |
| is_signed | input | 1 | Signed operands (modes 0, 1, 3) |
| clr_acc | input | 1 | Start a new sum with this product |
| rnd_en | input | 1 | Round extracted results |
| sat_en | input | 1 | Clamp accumulators and extracted results |
| out_valid | output | 1 | Accumulators hold a new result |
| acc0 | output | 40 | First accumulator |
| acc1 | output | 40 | Second accumulator |
| acc_wide | output | 72 | Chained accumulator {acc1[31:0], acc0} |
| res_lo | output | 16 | 16-bit result from acc0 |
| res_hi | output | 16 | 16-bit result from acc1 |
| res_wide | output | 32 | 32-bit result from the chained accumulator |
| ovf0 | output | 1 | Sticky clamp flag for acc0 |
| ovf1 | output | 1 | Sticky clamp flag for acc1 / wide |

## Verification
A corrupted accumulator shows on `acc0`/`acc1` two edges after the operation that caused it, and it stays there. Every later accumulation carries the error forward, unless an operation with `clr_acc` clears it. A wrong clamp decision is easiest to see at the limits. After 512 products of 2^30, a design that wraps correctly holds exactly −2^39, while a design that clamps holds the rail value. The sticky flags then show, on the next operation, whether the clamp was counted for the right accumulator. Extraction errors appear at the same time as the accumulator they read from, so they are checked together with it.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int OP_W   = 32;
  localparam int H_W    = OP_W / 2;
  localparam int ACC_W  = 40;
  localparam int GRD_W  = ACC_W - OP_W;
  localparam int WACC_W = ACC_W + OP_W;
  localparam int LANES  = 2;

  typedef enum logic [1:0] {
    MODE_DUAL = 2'd0,
    MODE_WIDE = 2'd1,
    MODE_CPLX = 2'd2,
    MODE_ALT  = 2'd3
  } mac_mode_e;

  typedef struct packed {
    logic             clip;
    logic [ACC_W-1:0] val;
  } sum_n_t;

  typedef struct packed {
    logic              clip;
    logic [WACC_W-1:0] val;
  } sum_w_t;

  typedef struct packed {
    logic              valid;
    logic [1:0]        mode;
    logic              clr;
    logic              rnd;
    logic              sat;
    logic [ACC_W-1:0]  p0;
    logic [ACC_W-1:0]  p1;
    logic [WACC_W-1:0] pw;
  } stage1_t;

  // Half-width product, extended to accumulator width.
  function automatic logic [ACC_W-1:0] mul_half(input logic [H_W-1:0] x, input logic [H_W-1:0] y,
                                                input logic sgn);
    logic signed [H_W:0]     xe, ye;
    logic signed [2*H_W+1:0] p;
    xe = $signed({sgn & x[H_W-1], x});
    ye = $signed({sgn & y[H_W-1], y});
    p  = xe * ye;
    return {{(ACC_W-2*H_W-2){p[2*H_W+1]}}, p};
  endfunction

  // Full-width product, extended to chained accumulator width.
  function automatic logic [WACC_W-1:0] mul_full(input logic [OP_W-1:0] x, input logic [OP_W-1:0] y,
                                                 input logic sgn);
    logic signed [OP_W:0]     xe, ye;
    logic signed [2*OP_W+1:0] p;
    xe = $signed({sgn & x[OP_W-1], x});
    ye = $signed({sgn & y[OP_W-1], y});
    p  = xe * ye;
    return {{(WACC_W-2*OP_W-2){p[2*OP_W+1]}}, p};
  endfunction

  function automatic sum_n_t add_n(input logic [ACC_W-1:0] a, input logic [ACC_W-1:0] b,
                                   input logic sat);
    logic [ACC_W:0] s;
    sum_n_t r;
    s = {a[ACC_W-1], a} + {b[ACC_W-1], b};
    r.clip = sat & (s[ACC_W] ^ s[ACC_W-1]);
    if (r.clip) r.val = s[ACC_W] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
    else        r.val = s[ACC_W-1:0];
    return r;
  endfunction

  function automatic sum_w_t add_w(input logic [WACC_W-1:0] a, input logic [WACC_W-1:0] b,
                                   input logic sat);
    logic [WACC_W:0] s;
    sum_w_t r;
    s = {a[WACC_W-1], a} + {b[WACC_W-1], b};
    r.clip = sat & (s[WACC_W] ^ s[WACC_W-1]);
    if (r.clip) r.val = s[WACC_W] ? {1'b1, {(WACC_W-1){1'b0}}} : {1'b0, {(WACC_W-1){1'b1}}};
    else        r.val = s[WACC_W-1:0];
    return r;
  endfunction

  // Upper half of the low word, rounded and clamped to the signed word range.
  function automatic logic [H_W-1:0] pick_half(input logic [ACC_W-1:0] a, input logic rnd,
                                               input logic sat);
    logic [ACC_W:0] v;
    logic           fits;
    v    = {a[ACC_W-1], a} + (rnd ? (ACC_W+1)'(1) << (H_W-1) : '0);
    fits = (&v[ACC_W:OP_W-1]) | ~(|v[ACC_W:OP_W-1]);
    if (sat && !fits) return v[ACC_W] ? {1'b1, {(H_W-1){1'b0}}} : {1'b0, {(H_W-1){1'b1}}};
    return v[OP_W-1:H_W];
  endfunction

  function automatic logic [OP_W-1:0] pick_word(input logic [WACC_W-1:0] a, input logic rnd,
                                                input logic sat);
    logic [WACC_W:0] v;
    logic            fits;
    v    = {a[WACC_W-1], a} + (rnd ? (WACC_W+1)'(1) << (OP_W-1) : '0);
    fits = (&v[WACC_W:2*OP_W-1]) | ~(|v[WACC_W:2*OP_W-1]);
    if (sat && !fits) return v[WACC_W] ? {1'b1, {(OP_W-1){1'b0}}} : {1'b0, {(OP_W-1){1'b1}}};
    return v[2*OP_W-1:OP_W];
  endfunction
endpackage

// File: rtl/dmac_mult.sv
module dmac_mult
  import dmac_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [OP_W-1:0] op_a,
  input  logic [OP_W-1:0] op_b,
  input  logic [1:0]      mode,
  input  logic            is_signed,
  input  logic            clr_acc,
  input  logic            rnd_en,
  input  logic            sat_en,
  output stage1_t         s1
);
  logic [H_W-1:0]    a_re, a_im, b_re, b_im;
  logic [ACC_W-1:0]  pl, ph, c_rr, c_ii, c_ri, c_ir;
  logic [WACC_W-1:0] pw;
  logic              is_cplx;

  assign a_re = op_a[OP_W-1:H_W];
  assign a_im = op_a[H_W-1:0];
  assign b_re = op_b[OP_W-1:H_W];
  assign b_im = op_b[H_W-1:0];
  assign is_cplx = (mode == MODE_CPLX);

  always_comb begin
    pl   = mul_half(a_im, b_im, is_signed);
    ph   = mul_half(a_re, b_re, is_signed);
    c_rr = mul_half(a_re, b_re, 1'b1);
    c_ii = mul_half(a_im, b_im, 1'b1);
    c_ri = mul_half(a_re, b_im, 1'b1);
    c_ir = mul_half(a_im, b_re, 1'b1);
    pw   = mul_full(op_a, op_b, is_signed);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
    end else begin
      s1.valid <= in_valid;
      if (in_valid) begin
        s1.mode <= mode;
        s1.clr  <= clr_acc;
        s1.rnd  <= rnd_en;
        s1.sat  <= sat_en;
        s1.p0   <= is_cplx ? c_rr - c_ii : pl;
        s1.p1   <= is_cplx ? c_ri + c_ir : ph;
        s1.pw   <= pw;
      end
    end
  end
endmodule

// File: rtl/dmac_acc.sv
module dmac_acc
  import dmac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  stage1_t          s1,
  output logic [ACC_W-1:0] acc0,
  output logic [ACC_W-1:0] acc1,
  output logic             ovf0,
  output logic             ovf1,
  output logic             out_valid,
  output logic             rnd_q,
  output logic             sat_q,
  output logic             clamp0_evt,
  output logic             clamp1_evt
);
  logic [LANES-1:0][ACC_W-1:0] cur, prod;
  sum_n_t [LANES-1:0]          lane_r;
  logic [WACC_W-1:0]           wbase;
  sum_w_t                      wide_r;
  logic                        is_wide;

  assign cur[0]  = acc0;
  assign cur[1]  = acc1;
  assign prod[0] = s1.p0;
  assign prod[1] = s1.p1;
  assign is_wide = (s1.mode == MODE_WIDE);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_r[g] = add_n(s1.clr ? '0 : cur[g], prod[g], s1.sat);
  end

  assign wbase  = s1.clr ? '0 : {acc1[OP_W-1:0], acc0};
  assign wide_r = add_w(wbase, s1.pw, s1.sat);

  assign clamp0_evt = s1.valid & ~is_wide & lane_r[0].clip;
  assign clamp1_evt = s1.valid & (is_wide ? wide_r.clip : lane_r[1].clip);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc0      <= '0;
      acc1      <= '0;
      ovf0      <= 1'b0;
      ovf1      <= 1'b0;
      out_valid <= 1'b0;
      rnd_q     <= 1'b0;
      sat_q     <= 1'b0;
    end else begin
      out_valid <= s1.valid;
      ovf0      <= ovf0 | clamp0_evt;
      ovf1      <= ovf1 | clamp1_evt;
      if (s1.valid) begin
        rnd_q <= s1.rnd;
        sat_q <= s1.sat;
        if (is_wide) begin
          acc0 <= wide_r.val[ACC_W-1:0];
          acc1 <= {{GRD_W{wide_r.val[WACC_W-1]}}, wide_r.val[WACC_W-1:ACC_W]};
        end else begin
          acc0 <= lane_r[0].val;
          acc1 <= lane_r[1].val;
        end
      end
    end
  end
endmodule

// File: rtl/dmac_extract.sv
module dmac_extract
  import dmac_pkg::*;
(
  input  logic [ACC_W-1:0]  acc0,
  input  logic [ACC_W-1:0]  acc1,
  input  logic              rnd_q,
  input  logic              sat_q,
  output logic [WACC_W-1:0] acc_wide,
  output logic [H_W-1:0]    res_lo,
  output logic [H_W-1:0]    res_hi,
  output logic [OP_W-1:0]   res_wide
);
  assign acc_wide = {acc1[OP_W-1:0], acc0};
  assign res_lo   = pick_half(acc0, rnd_q, sat_q);
  assign res_hi   = pick_half(acc1, rnd_q, sat_q);
  assign res_wide = pick_word(acc_wide, rnd_q, sat_q);
endmodule

// File: rtl/dmac_unit.sv
module dmac_unit
  import dmac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  input  logic [1:0]        mode,
  input  logic              is_signed,
  input  logic              clr_acc,
  input  logic              rnd_en,
  input  logic              sat_en,
  output logic              out_valid,
  output logic [ACC_W-1:0]  acc0,
  output logic [ACC_W-1:0]  acc1,
  output logic [WACC_W-1:0] acc_wide,
  output logic [H_W-1:0]    res_lo,
  output logic [H_W-1:0]    res_hi,
  output logic [OP_W-1:0]   res_wide,
  output logic              ovf0,
  output logic              ovf1
);
  stage1_t s1;
  logic    rnd_q, sat_q;
  logic    clamp0_evt, clamp1_evt;

  dmac_mult u_mult (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .mode(mode), .is_signed(is_signed), .clr_acc(clr_acc), .rnd_en(rnd_en),
    .sat_en(sat_en), .s1(s1)
  );

  dmac_acc u_acc (
    .clk(clk), .rst_n(rst_n), .s1(s1), .acc0(acc0), .acc1(acc1),
    .ovf0(ovf0), .ovf1(ovf1), .out_valid(out_valid), .rnd_q(rnd_q),
    .sat_q(sat_q), .clamp0_evt(clamp0_evt), .clamp1_evt(clamp1_evt)
  );

  dmac_extract u_ext (
    .acc0(acc0), .acc1(acc1), .rnd_q(rnd_q), .sat_q(sat_q),
    .acc_wide(acc_wide), .res_lo(res_lo), .res_hi(res_hi), .res_wide(res_wide)
  );
endmodule

// File: rtl/dmac_chk.sv
module dmac_chk
  import dmac_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [OP_W-1:0]  op_a,
  input logic [1:0]       mode,
  input logic             clr_acc,
  input logic             out_valid,
  input logic [ACC_W-1:0] acc0,
  input logic [ACC_W-1:0] acc1,
  input logic             ovf0,
  input logic             ovf1,
  input logic             clamp0_evt,
  input logic             clamp1_evt
);
  logic [1:0] age;
  logic       armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      age <= '0;
    else if (!armed) age <= age + 2'd1;
  end
  assign armed = (age == 2'd3);

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (out_valid == $past(in_valid, 2)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(in_valid, 2)) |-> ($stable(acc0) && $stable(acc1)));

  assert_sticky0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(ovf0)) |-> ovf0);

  assert_sticky1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(ovf1)) |-> ovf1);

  assert_clamp_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(clamp0_evt) && $past(clamp1_evt)) |-> (ovf0 && ovf1));

  assert_rail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $rose(ovf0)) |->
      (acc0 == {1'b0, {(ACC_W-1){1'b1}}} || acc0 == {1'b1, {(ACC_W-1){1'b0}}}));

  assert_guard_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && out_valid && $past(mode, 2) == MODE_WIDE) |->
      (acc1[ACC_W-1:OP_W] == {GRD_W{acc1[OP_W-1]}}));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_valid, 2) && $past(clr_acc, 2) && $past(op_a, 2) == '0) |->
      (acc0 == '0 && acc1 == '0));
endmodule

bind dmac_unit dmac_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .mode(mode),
  .clr_acc(clr_acc), .out_valid(out_valid), .acc0(acc0), .acc1(acc1),
  .ovf0(ovf0), .ovf1(ovf1), .clamp0_evt(clamp0_evt), .clamp1_evt(clamp1_evt)
);

// File: tb/sim_dmac_unit.sv
module sim_dmac_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [1:0]  mode = '0;
  logic        is_signed = 1'b0, clr_acc = 1'b0, rnd_en = 1'b0, sat_en = 1'b0;
  logic        out_valid, ovf0, ovf1;
  logic [39:0] acc0, acc1;
  logic [71:0] acc_wide;
  logic [15:0] res_lo, res_hi;
  logic [31:0] res_wide;

  int total = 0, bad = 0;
  bit finished = 0;

  // bench-side reference state
  logic [39:0] m0 = '0, m1 = '0;
  logic        mo0 = 0, mo1 = 0, mrnd = 0, msat = 0;

  always #5 clk = ~clk;

  dmac_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .mode(mode), .is_signed(is_signed), .clr_acc(clr_acc), .rnd_en(rnd_en),
    .sat_en(sat_en), .out_valid(out_valid), .acc0(acc0), .acc1(acc1),
    .acc_wide(acc_wide), .res_lo(res_lo), .res_hi(res_hi), .res_wide(res_wide),
    .ovf0(ovf0), .ovf1(ovf1)
  );

  task automatic check(input string req, input string what, input logic [71:0] act,
                       input logic [71:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // lane update: 40-bit signed sum, clamp or wrap
  task automatic lane(inout logic [39:0] m, inout logic mo, input longint p, input bit clr,
                      input bit sat);
    longint s, lim;
    lim = longint'(1) <<< 39;
    s = (clr ? 64'sd0 : longint'($signed(m))) + p;
    if (sat && s > lim - 1)   begin m = 40'h7F_FFFF_FFFF; mo = 1; end
    else if (sat && s < -lim) begin m = 40'h80_0000_0000; mo = 1; end
    else m = s[39:0];
  endtask

  task automatic model_op(input logic [31:0] a, input logic [31:0] b, input logic [1:0] md,
                          input bit sgn, input bit clr, input bit rnd, input bit sat);
    longint xa, xb, ya, yb;
    logic signed [95:0] wa, wb, wacc, ws, wmax;
    mrnd = rnd; msat = sat;
    if (md == 2'd1) begin
      wa = sgn ? {{64{a[31]}}, a} : {64'b0, a};
      wb = sgn ? {{64{b[31]}}, b} : {64'b0, b};
      wacc = clr ? 96'sd0 : {{24{m1[31]}}, m1[31:0], m0};
      ws = wacc + wa * wb;
      wmax = (96'sd1 <<< 71) - 96'sd1;
      if (sat && ws > wmax)           begin ws = wmax; mo1 = 1; end
      else if (sat && ws < -wmax - 1) begin ws = -wmax - 1; mo1 = 1; end
      m0 = ws[39:0];
      m1 = {{8{ws[71]}}, ws[71:40]};
    end else if (md == 2'd2) begin
      xa = longint'($signed(a[31:16])); ya = longint'($signed(a[15:0]));
      xb = longint'($signed(b[31:16])); yb = longint'($signed(b[15:0]));
      lane(m0, mo0, xa * xb - ya * yb, clr, sat);
      lane(m1, mo1, xa * yb + ya * xb, clr, sat);
    end else begin
      if (sgn) begin
        xa = longint'($signed(a[31:16])); ya = longint'($signed(a[15:0]));
        xb = longint'($signed(b[31:16])); yb = longint'($signed(b[15:0]));
      end else begin
        xa = longint'(a[31:16]); ya = longint'(a[15:0]);
        xb = longint'(b[31:16]); yb = longint'(b[15:0]);
      end
      lane(m0, mo0, ya * yb, clr, sat);
      lane(m1, mo1, xa * xb, clr, sat);
    end
  endtask

  function automatic logic [15:0] exp_half(input logic [39:0] m);
    longint v;
    v = longint'($signed(m)) + (mrnd ? 64'sd32768 : 64'sd0);
    if (msat && v > 64'sd2147483647)  return 16'h7FFF;
    if (msat && v < -64'sd2147483648) return 16'h8000;
    return v[31:16];
  endfunction

  function automatic logic [31:0] exp_word();
    logic signed [95:0] v, lim;
    v = {{24{m1[31]}}, m1[31:0], m0};
    if (mrnd) v = v + (96'sd1 <<< 31);
    lim = 96'sd1 <<< 63;
    if (msat && v > lim - 1) return 32'h7FFF_FFFF;
    if (msat && v < -lim)    return 32'h8000_0000;
    return v[63:32];
  endfunction

  task automatic check_all(input string req);
    check(req, "acc0", {32'b0, acc0}, {32'b0, m0});
    check(req, "acc1", {32'b0, acc1}, {32'b0, m1});
    check(req, "acc_wide", acc_wide, {m1[31:0], m0});
    check("R8", "res_lo", {56'b0, res_lo}, {56'b0, exp_half(m0)});
    check("R8", "res_hi", {56'b0, res_hi}, {56'b0, exp_half(m1)});
    check("R9", "res_wide", {40'b0, res_wide}, {40'b0, exp_word()});
    check("R6", "ovf", {70'b0, ovf1, ovf0}, {70'b0, mo1, mo0});
  endtask

  // n back-to-back operations; clr on the first one only when asked
  task automatic run(input logic [31:0] a, input logic [31:0] b, input logic [1:0] md,
                     input bit sgn, input bit clr_first, input bit rnd, input bit sat,
                     input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1; op_a = a; op_b = b; mode = md; is_signed = sgn;
      clr_acc = clr_first && (i == 0); rnd_en = rnd; sat_en = sat;
      model_op(a, b, md, sgn, clr_first && (i == 0), rnd, sat);
    end
    @(negedge clk);
    in_valid = 0; clr_acc = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R10", "acc0", {32'b0, acc0}, '0);
    check("R10", "acc1", {32'b0, acc1}, '0);
    check("R10", "res", {24'b0, res_wide, res_hi, res_lo}, '0);
    check("R10", "flags", {69'b0, out_valid, ovf1, ovf0}, '0);
  endtask

  task automatic t_latency();
    @(negedge clk);
    in_valid = 1; op_a = 32'h0002_0003; op_b = 32'h0004_0005; mode = 2'd0;
    is_signed = 1; clr_acc = 1; rnd_en = 0; sat_en = 0;
    model_op(op_a, op_b, 2'd0, 1, 1, 0, 0);
    @(negedge clk);
    in_valid = 0; clr_acc = 0;
    check("R7", "out_valid one edge after", {71'b0, out_valid}, 72'd0);
    check("R7", "acc0 not yet updated", {32'b0, acc0}, 72'd0);
    @(negedge clk);
    check("R7", "out_valid two edges after", {71'b0, out_valid}, 72'd1);
    check_all("R7");
    @(negedge clk);
    check("R7", "out_valid drops", {71'b0, out_valid}, 72'd0);
    repeat (3) @(negedge clk);
    check("R7", "acc0 held when idle", {32'b0, acc0}, {32'b0, m0});
  endtask

  task automatic t_dual();
    run(32'h0003_FFFE, 32'h0005_0007, 2'd0, 1, 1, 0, 0, 1);
    check("R1", "acc0 = -14", {32'b0, acc0}, {32'b0, 40'hFF_FFFF_FFF2});
    check("R1", "acc1 = 15", {32'b0, acc1}, 72'd15);
    run(32'h0003_FFFE, 32'h0005_0007, 2'd0, 1, 0, 0, 0, 3);
    check_all("R1");
    run(32'hFFFF_FFFF, 32'h0002_FFFF, 2'd0, 0, 1, 0, 0, 1);
    check("R1", "unsigned lo", {32'b0, acc0}, {32'b0, 40'h00_FFFE_0001});
    check_all("R1");
    run(32'h1234_8001, 32'hFEDC_7FFF, 2'd3, 1, 0, 0, 0, 2);
    check_all("R1");
    run(32'h0000_0000, 32'h5555_AAAA, 2'd0, 1, 1, 0, 0, 1);
    check_all("R4");
  endtask

  task automatic t_wide();
    run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd1, 0, 1, 0, 0, 1);
    check("R2", "unsigned max", acc_wide, 72'h00_FFFF_FFFE_0000_0001);
    run(32'h8000_0000, 32'h7FFF_FFFF, 2'd1, 1, 1, 0, 0, 1);
    check_all("R2");
    check("R2", "guard bits", {64'b0, acc1[39:32]}, {64'b0, {8{acc1[31]}}});
    run(32'h1234_5678, 32'h9ABC_DEF0, 2'd1, 1, 0, 1, 0, 3);
    check_all("R2");
  endtask

  task automatic t_complex();
    run(32'h0003_0004, 32'h0005_FFFE, 2'd2, 0, 1, 0, 0, 1);
    check("R3", "real 3*5-4*(-2)=23", {32'b0, acc0}, 72'd23);
    check("R3", "imag 3*(-2)+4*5=14", {32'b0, acc1}, 72'd14);
    run(32'h8000_8000, 32'h8000_7FFF, 2'd2, 1, 0, 0, 1, 2);
    check_all("R3");
  endtask

  task automatic t_saturate();
    run(32'h8000_8000, 32'h8000_8000, 2'd0, 1, 1, 0, 0, 512);
    check("R5", "wrap to -2^39", {32'b0, acc0}, {32'b0, 40'h80_0000_0000});
    check("R6", "no flag on wrap", {70'b0, ovf1, ovf0}, 72'd0);
    run(32'h8000_8000, 32'h8000_7FFF, 2'd0, 1, 0, 0, 1, 1);
    check("R5", "clamp to min", {32'b0, acc0}, {32'b0, 40'h80_0000_0000});
    check("R5", "acc1 in range", {32'b0, acc1}, {32'b0, 40'h80_4000_0000});
    check("R6", "ovf0 only", {70'b0, ovf1, ovf0}, 72'd1);
    run(32'h0000_0000, 32'h0000_0000, 2'd0, 1, 1, 0, 0, 1);
    check("R6", "ovf0 sticky", {71'b0, ovf0}, 72'd1);
    run(32'h8000_0000, 32'h8000_0000, 2'd1, 1, 1, 0, 1, 512);
    check("R5", "wide clamp", acc_wide, 72'h7F_FFFF_FFFF_FFFF_FFFF);
    check("R9", "wide result sat", {40'b0, res_wide}, 72'h7FFF_FFFF);
    check("R6", "ovf1 from wide", {71'b0, ovf1}, 72'd1);
    check_all("R5");
  endtask

  task automatic t_extract();
    run(32'h0000_0001, 32'h0000_8000, 2'd0, 0, 1, 1, 0, 1);
    check("R8", "tie rounds up", {56'b0, res_lo}, 72'd1);
    run(32'h0000_0001, 32'h0000_8000, 2'd0, 0, 1, 0, 0, 1);
    check("R8", "truncate", {56'b0, res_lo}, 72'd0);
    run(32'h0000_FFFF, 32'h0000_FFFF, 2'd0, 0, 1, 0, 1, 1);
    check("R8", "sat positive", {56'b0, res_lo}, 72'h7FFF);
    run(32'h0000_FFFF, 32'h0000_FFFF, 2'd0, 0, 1, 0, 0, 1);
    check("R8", "no sat", {56'b0, res_lo}, 72'hFFFE);
    run(32'h0000_0001, 32'h8000_0000, 2'd1, 0, 1, 1, 0, 1);
    check("R9", "wide tie rounds up", {40'b0, res_wide}, 72'd1);
    run(32'h8000_8000, 32'h7FFF_7FFF, 2'd0, 1, 1, 1, 1, 3);
    check_all("R8");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_latency();
    t_dual();
    t_wide();
    t_complex();
    t_extract();
    t_saturate();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end
endmodule